// File: doc/BRIEF.md
# PHY Management Serial Controller

This block lets software run PHY management transactions through two registers. Software writes one command word that holds the PHY address, the register offset, the direction and, for writes, the data. The block then clocks a complete management frame on MDC and MDIO. While the frame runs, a busy flag is set in the same word. After a read, the captured data appears in the low half of the word and a read-valid flag is set. A second register holds a 5-bit default PHY address for software to keep.

MDC is derived from the system clock and runs only while a frame is in progress. The engine moves MDIO on falling MDC edges and samples the returning data on rising edges. On a read it stops driving MDIO at the turnaround, so the PHY can take the line.

Top module: `mgmt_serial_ctrl`

## Requirements
- R1: With `bus_sel_cmd`=0 the bus reaches the PHY-address register. A write stores `bus_wdata[4:0]`, and a read returns that value in bits 4:0 with bits 31:5 zero. The value after reset is 0.
- R2: With `bus_sel_cmd`=1 the bus reaches the command word. Its layout is: data in 15:0, PHY address in 20:16, register offset in 25:21, bit 26 set for a read and clear for a write, read-valid in bit 27, busy in bit 28, and bits 31:29 reading as zero. An accepted write stores the address, offset, direction and data fields as written.
- R3: Accepting a command sets busy. Busy reads 1 from the next cycle and stays set until the frame has finished.
- R4: A command write made while busy is set changes no field, and the running frame goes on unchanged.
- R5: A write frame has 64 bits, driven MSB first. These are 32 ones, start bits 0 then 1, opcode 0 then 1, five PHY-address bits, five register bits, turnaround 1 then 0, and then 16 data bits. MDIO is enabled for the whole frame.
- R6: A read frame drives the same first 34 bits, then opcode 1 then 0, then the address and register bits. From the turnaround bit (bit position 46) to the end of the frame, the output enable is low.
- R7: On a read, the 16 bits sampled on the rising MDC edges of frame positions 48 to 63 (MSB first) are returned in bits 15:0 when the frame ends, and read-valid is set.
- R8: Read-valid clears when the next command is accepted.
- R9: While a frame runs, MDC is high for `MDC_HALF` clock cycles and low for `MDC_HALF` cycles. When idle, MDC is low and MDIO is not driven.
- R10: Busy clears in the cycle after the final MDC fall. A command write in the cycle of that fall is ignored. The first write presented while busy reads 0 is the one accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel_cmd | input | 1 | 1 selects the command word, 0 selects the PHY-address register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | MDIO line as seen at the pad |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The end of a frame and a new command write can fall in the same cycle. The bench provokes this by presenting a fresh, uniquely tagged command write on every cycle while a read frame is still running. In each cycle it reads the busy flag before the edge. The tag presented in the first cycle where busy reads 0 must be the one stored. In that same cycle the word must still show the completed read's data with read-valid set, and the accepted tag's frame must then appear on the wire intact.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  typedef struct packed {
    logic        busy;
    logic        rvalid;
    logic        rd;
    logic [4:0]  regad;
    logic [4:0]  phy;
    logic [15:0] data;
  } cmd_word_t;

  // Whole frame, first bit on the wire in bit 63.
  function automatic logic [FRAME_BITS-1:0] frame_word(input logic rd,
      input logic [4:0] phy, input logic [4:0] regad, input logic [15:0] wdata);
    logic [1:0] opc;
    logic [1:0] ta;
    opc = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, regad, ta, rd ? 16'h0000 : wdata};
  endfunction

  // Whether the controller owns the line at a given frame position.
  function automatic logic drives_bit(input logic rd, input logic [5:0] idx);
    return !rd || (idx < 6'(TA_POS));
  endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick     = run && (cnt_q == CW'(HALF - 1));
  assign rise_evt = tick && !mdc_q;
  assign fall_evt = tick && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: the clock parks low whenever no frame runs
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R9: a rise event leaves the clock high
  a_r9_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> mdc);

endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_rd,
  input  logic [4:0]  start_phy,
  input  logic [4:0]  start_reg,
  input  logic [15:0] start_data,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_in,
  output logic        active,
  output logic        done,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic [15:0] rdata
);
  logic                  active_q;
  logic                  rd_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [5:0]            bit_q;
  logic [15:0]           rdata_q;
  logic                  last_bit;
  logic                  capture;

  assign last_bit = (bit_q == 6'(FRAME_BITS - 1));
  assign done     = active_q && fall_evt && last_bit;
  assign capture  = active_q && rise_evt && rd_q && (bit_q >= 6'(DATA_POS));
  assign active   = active_q;
  assign mdio_out = frame_q[FRAME_BITS-1];
  assign mdio_oe  = active_q && drives_bit(rd_q, bit_q);
  assign rdata    = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      frame_q  <= '0;
      bit_q    <= '0;
      rdata_q  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      rd_q     <= start_rd;
      frame_q  <= frame_word(start_rd, start_phy, start_reg, start_data);
      bit_q    <= '0;
      rdata_q  <= '0;
    end else begin
      if (active_q && fall_evt) begin
        frame_q <= frame_q << 1;
        if (last_bit) active_q <= 1'b0;
        else          bit_q    <= bit_q + 1'b1;
      end
      if (capture) rdata_q <= {rdata_q[14:0], mdio_in};
    end
  end

  // R6: the line is released whenever read data is being sampled
  a_r6_released_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !mdio_oe);
  // R5: the output moves only on a falling MDC edge or a frame start
  a_r5_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !fall_evt && !start) |=> $stable(mdio_out));
  // R10: the frame ends right after its final fall
  a_r10_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active_q);

endmodule

// File: rtl/mgmt_serial_ctrl.sv
module mgmt_serial_ctrl
  import mgmt_pkg::*;
#(
  parameter int         MDC_HALF = 4,
  parameter logic [4:0] PHY_RST  = 5'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_sel_cmd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe
);
  cmd_word_t   cmd_q;
  logic [4:0]  phy_q;
  logic        accept;
  logic        eng_active;
  logic        eng_done;
  logic [15:0] eng_rdata;
  logic        rise_evt;
  logic        fall_evt;
  logic        unused_bits;

  assign unused_bits = ^bus_wdata[31:27];
  assign accept      = bus_wr && bus_sel_cmd && !cmd_q.busy;
  assign bus_rdata   = bus_sel_cmd ? {3'b000, cmd_q} : {27'd0, phy_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      phy_q <= PHY_RST;
    end else begin
      if (bus_wr && !bus_sel_cmd) phy_q <= bus_wdata[4:0];
      if (accept) begin
        cmd_q.busy   <= 1'b1;
        cmd_q.rvalid <= 1'b0;
        cmd_q.rd     <= bus_wdata[26];
        cmd_q.regad  <= bus_wdata[25:21];
        cmd_q.phy    <= bus_wdata[20:16];
        cmd_q.data   <= bus_wdata[15:0];
      end else if (eng_done) begin
        cmd_q.busy <= 1'b0;
        if (cmd_q.rd) begin
          cmd_q.data   <= eng_rdata;
          cmd_q.rvalid <= 1'b1;
        end
      end
    end
  end

  mgmt_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (eng_active),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mgmt_frame_eng u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_rd   (bus_wdata[26]),
    .start_phy  (bus_wdata[20:16]),
    .start_reg  (bus_wdata[25:21]),
    .start_data (bus_wdata[15:0]),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .mdio_in    (mdio_in),
    .active     (eng_active),
    .done       (eng_done),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .rdata      (eng_rdata)
  );

  // R3: the busy flag follows the frame engine exactly
  a_r3_busy_tracks_engine: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.busy == eng_active);
  // R4: a command write while busy leaves the command fields alone
  a_r4_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel_cmd && cmd_q.busy) |=>
      ($stable(cmd_q.phy) && $stable(cmd_q.regad) && $stable(cmd_q.rd)));
  // R8: an accepted command clears read-valid
  a_r8_rvalid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!cmd_q.rvalid && cmd_q.busy));
  // R7: read-valid rises only at the end of a read frame
  a_r7_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_q.rvalid) |-> ($past(eng_done) && cmd_q.rd));
  // R9: the line is driven only while a frame runs
  a_r9_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> cmd_q.busy);

endmodule

// File: tb/mgmt_serial_ctrl_tb.sv
module mgmt_serial_ctrl_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel_cmd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc;
  logic        mdio_in = 1'b1;
  logic        mdio_out;
  logic        mdio_oe;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // PHY model state
  int          idx = 0;
  logic [63:0] cap_bit;
  logic [63:0] cap_oe;
  logic [15:0] phy_val = '0;
  int          per_bad = 0;
  longint      t_rise = 0;
  longint      t_fall = 0;

  always #5 clk = !clk;

  mgmt_serial_ctrl #(.MDC_HALF(HALF), .PHY_RST(5'd0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_cmd(bus_sel_cmd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  always @(posedge mdc) begin
    if (idx < 64) begin
      cap_bit[idx] = mdio_out;
      cap_oe[idx]  = mdio_oe;
    end
    if (idx > 0 && idx < 64 && ($time - t_fall) != longint'(HALF * 10)) per_bad++;
    t_rise = $time;
  end

  always @(negedge mdc) begin
    if (($time - t_rise) != longint'(HALF * 10)) per_bad++;
    t_fall = $time;
    idx++;
    if (idx >= 48 && idx < 64) mdio_in = phy_val[63 - idx];
    else mdio_in = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel_cmd = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b0; bus_sel_cmd = sel;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    rd(1'b1, v);
    while (v[28]) rd(1'b1, v);
  endtask

  function automatic logic [31:0] cmd_word(input logic r, input logic [4:0] p,
      input logic [4:0] g, input logic [15:0] d);
    return (32'(r) << 26) | (32'(g) << 21) | (32'(p) << 16) | 32'(d);
  endfunction

  function automatic logic exp_bit(input int i, input logic r, input logic [4:0] p,
      input logic [4:0] g, input logic [15:0] d);
    if (i < 32) return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return r;
    if (i == 35) return !r;
    if (i <= 40) return p[40 - i];
    if (i <= 45) return g[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return d[63 - i];
  endfunction

  task automatic check_frame(input logic r, input logic [4:0] p, input logic [4:0] g,
      input logic [15:0] d, input string req);
    int errs = 0;
    for (int i = 0; i < 64; i++) begin
      if (cap_oe[i] != (!r || i < 46)) errs++;
      if ((!r || i < 46) && cap_bit[i] != exp_bit(i, r, p, g, d)) errs++;
    end
    check(errs == 0 && idx == 64, req, 32'(errs), 32'd0);
    check(per_bad == 0, "R9", 32'(per_bad), 32'd0);
  endtask

  task automatic issue(input logic [31:0] w);
    idx = 0; per_bad = 0;
    wr(1'b1, w);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] seen;
    logic [4:0]  p, g;
    logic [15:0] d;
    int          k;
    int          acc;
    bit          found;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 reset values
    rd(1'b0, v); check(v == 32'd0, "R1 reset phy reg", v, 32'd0);
    rd(1'b1, v); check(v == 32'd0, "R2 reset cmd word", v, 32'd0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle lines", {30'd0, mdc, mdio_oe}, 32'd0);

    // R1 only bits 4:0 of the PHY-address register are kept
    wr(1'b0, 32'hFFFF_FFEA); rd(1'b0, v); check(v == 32'h0A, "R1 masked", v, 32'h0A);
    wr(1'b0, 32'h0000_0013); rd(1'b0, v); check(v == 32'h13, "R1 value", v, 32'h13);
    rd(1'b1, v); check(v == 32'd0, "R1 cmd untouched", v, 32'd0);

    // R5 write frames over a sweep of fields
    for (int i = 0; i < 6; i++) begin
      p = 5'((i * 5 + 3) % 32);
      g = 5'((i * 11 + 1) % 32);
      d = 16'((i * 16'h1357) ^ 16'hA5C3);
      issue(cmd_word(1'b0, p, g, d) | 32'hE800_0000);
      rd(1'b1, v);
      check(v == (cmd_word(1'b0, p, g, d) | 32'h1000_0000), "R2 R3 fields busy", v,
            cmd_word(1'b0, p, g, d) | 32'h1000_0000);
      if (i == 2) begin
        // R4 command while busy is ignored
        wr(1'b1, cmd_word(1'b1, ~p, ~g, ~d));
        rd(1'b1, v);
        check(v == (cmd_word(1'b0, p, g, d) | 32'h1000_0000), "R4 ignored", v,
              cmd_word(1'b0, p, g, d) | 32'h1000_0000);
      end
      wait_idle();
      check_frame(1'b0, p, g, d, i == 2 ? "R4 frame intact" : "R5");
      rd(1'b1, v);
      check(v == cmd_word(1'b0, p, g, d), "R3 busy cleared", v, cmd_word(1'b0, p, g, d));
    end

    // R6 / R7 read frames and returned data
    for (int i = 0; i < 6; i++) begin
      p = 5'((i * 7 + 2) % 32);
      g = 5'((i * 3 + 30) % 32);
      phy_val = 16'((i * 16'h2F1D) ^ 16'h5A3C);
      issue(cmd_word(1'b1, p, g, 16'hFFFF));
      wait_idle();
      check_frame(1'b1, p, g, 16'h0, "R6");
      rd(1'b1, v);
      check(v == (cmd_word(1'b1, p, g, phy_val) | 32'h0800_0000), "R7 read data", v,
            cmd_word(1'b1, p, g, phy_val) | 32'h0800_0000);
    end

    // R8 read-valid clears on the next accepted command
    issue(cmd_word(1'b0, 5'd4, 5'd5, 16'h0F0F));
    rd(1'b1, v);
    check(v[28:27] == 2'b10, "R8 rvalid cleared", {30'd0, v[28:27]}, 32'd2);
    wait_idle();
    check_frame(1'b0, 5'd4, 5'd5, 16'h0F0F, "R8 frame");

    // R10 completion and new command in adjacent cycles
    phy_val = 16'hC3A5;
    issue(cmd_word(1'b1, 5'd1, 5'd2, 16'h0));
    found = 0; k = 0; acc = 0; seen = '0;
    while (!found && k < 4000) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_sel_cmd = 1'b1;
      bus_wdata = cmd_word(1'b0, 5'd9, 5'd17, 16'(k));
      #1;
      if (!bus_rdata[28]) begin
        found = 1; seen = bus_rdata; acc = k;
        idx = 0; per_bad = 0;
      end
      k++;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    #1 v = bus_rdata;
    check(seen == (cmd_word(1'b1, 5'd1, 5'd2, 16'hC3A5) | 32'h0800_0000),
          "R10 completed word", seen, cmd_word(1'b1, 5'd1, 5'd2, 16'hC3A5) | 32'h0800_0000);
    check(v == (cmd_word(1'b0, 5'd9, 5'd17, 16'(acc)) | 32'h1000_0000), "R10 accepted tag", v,
          cmd_word(1'b0, 5'd9, 5'd17, 16'(acc)) | 32'h1000_0000);
    wait_idle();
    check_frame(1'b0, 5'd9, 5'd17, 16'(acc), "R10 frame");
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle after", {30'd0, mdc, mdio_oe}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule